// File: doc/BRIEF.md
# Virtual Plane Tag Codec for a Multi-Root Link

This block sits in the data link layer of a port that shares one physical link among several virtual planes. On the transmit side it takes the TLP words of one packet, together with the link sequence number and the virtual plane (VP) number the packet belongs to. It emits a framed packet on the link in this order: a sequence word, a VP tag word, the TLP words unchanged, and a trailing link CRC word. The CRC covers the tag as well as the sequence number and the TLP. Any end-to-end CRC inside the TLP is left untouched, so it remains valid after the tag is removed. A retransmit request makes the block reuse the VP number recorded when that sequence number was first sent, so a replayed packet carries the same tag as the original.

On the receive side it buffers a whole frame and checks its length, its link CRC and, in multi-root mode, its tag marker. A frame that passes is handed upstream as the bare TLP with its VP number and sequence number. A frame that fails is dropped and an error pulse is raised. A link-wide enable chooses between multi-root framing and plain base framing. Base framing carries no tag, and the VP number reported upstream is forced to zero. Each direction samples the enable at the first word of a frame.

Top module: `vp_tag_codec`

## Requirements
- R1: In multi-root mode a transmitted frame is, in order: the sequence word {20'h0, seq[11:0]}, the tag word {8'hA5, 8'h00, vp[7:0], 8'h00}, every TLP word unchanged and in order, then the CRC word. lnk_tx_sop is high only on the sequence word and lnk_tx_eop only on the CRC word.
- R2: The CRC word is the bitwise complement of a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. The CRC is run over every preceding word of the frame (sequence, tag when present, TLP), each word fed most significant bit first, with no reflection.
- R3: When mr_en is low at the start of a frame, the transmitter emits no tag word (sequence, TLP, CRC) and the receiver expects none and reports tl_rx_vp = 0.
- R4: With tl_tx_retry high on the first word, the tag carries the VP number stored when that sequence number (indexed by its low log2(REPLAY_DEPTH) bits) was last sent without retry; tl_tx_vp is ignored. The sequence word still comes from tl_tx_seq.
- R5: A received frame with correct length, CRC and (in multi-root mode) marker is delivered upstream as its TLP words unchanged and in order. tl_rx_sop is on the first word and tl_rx_eop on the last, with tl_rx_vp taken from the tag and tl_rx_seq from the sequence word.
- R6: A received frame whose last word differs from the expected CRC word is dropped: err_crc pulses for one cycle and nothing is delivered upstream.
- R7: In multi-root mode, a received frame whose tag word does not start with 8'hA5 is dropped and err_tag pulses, even when its CRC is correct.
- R8: A received frame carrying zero TLP words, or more than MAX_TLP_W TLP words, is dropped and err_len pulses. A frame carrying exactly MAX_TLP_W TLP words is accepted.
- R9: After reset, no link or upstream word is valid, tl_tx_ready is low, lnk_rx_ready is high and all error outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_en | input | 1 | 1 selects multi-root tagged framing, 0 selects base framing |
| tl_tx_valid | input | 1 | Transmit TLP word valid |
| tl_tx_sop | input | 1 | First TLP word of a packet |
| tl_tx_eop | input | 1 | Last TLP word of a packet |
| tl_tx_data | input | 32 | Transmit TLP word |
| tl_tx_seq | input | 12 | Link sequence number, held with the first word |
| tl_tx_vp | input | 8 | Virtual plane number, held with the first word |
| tl_tx_retry | input | 1 | Packet is a retransmission, held with the first word |
| tl_tx_ready | output | 1 | TLP word accepted on this cycle when valid |
| lnk_tx_valid | output | 1 | Link transmit word valid |
| lnk_tx_sop | output | 1 | First word of link frame |
| lnk_tx_eop | output | 1 | Last (CRC) word of link frame |
| lnk_tx_data | output | 32 | Link transmit word |
| lnk_rx_valid | input | 1 | Link receive word valid |
| lnk_rx_sop | input | 1 | First word of received frame |
| lnk_rx_eop | input | 1 | Last (CRC) word of received frame |
| lnk_rx_data | input | 32 | Link receive word |
| lnk_rx_ready | output | 1 | Receive word accepted on this cycle when valid |
| tl_rx_valid | output | 1 | Upstream TLP word valid |
| tl_rx_sop | output | 1 | First upstream TLP word |
| tl_rx_eop | output | 1 | Last upstream TLP word |
| tl_rx_data | output | 32 | Upstream TLP word |
| tl_rx_seq | output | 12 | Sequence number of delivered frame |
| tl_rx_vp | output | 8 | VP number of delivered frame |
| err_crc | output | 1 | One-cycle pulse: frame dropped on CRC |
| err_tag | output | 1 | One-cycle pulse: frame dropped on tag marker |
| err_len | output | 1 | One-cycle pulse: frame dropped on length |

## Verification
The bench replays a sequence number after sending a different one, with a new VP number on the retry. A design that read the live VP input would emit the wrong tag, while the expected CRC would still be computed over the original tag. It sends TLP words whose top byte equals the marker, and checks that the CRC includes the tag. A datapath that rewrote payload or left the tag out of the CRC would then fail the compare. On receive it probes frames with zero, exactly the maximum and one over the maximum TLP words, a frame with a bad marker but a valid CRC, and a single flipped CRC bit. It also switches to base mode to confirm no tag word is produced or expected and VP reads zero. Finally, a transmitted frame is looped back into the receiver.

// File: rtl/vp_tag_pkg.sv
package vp_tag_pkg;

    localparam int WORD_W = 32;
    localparam int SEQ_W  = 12;
    localparam int VP_W   = 8;

    localparam logic [7:0]        TAG_MARK  = 8'hA5;
    localparam logic [WORD_W-1:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        TXS_IDLE,
        TXS_TAG,
        TXS_BODY,
        TXS_CRC
    } tx_state_e;

    typedef enum logic {
        RXS_COLLECT,
        RXS_PLAY
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } lane_t;

    // One 32-bit word folded into the running CRC, MSB first.
    function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                   input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        logic              fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ d[i];
            r  = {r[WORD_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] make_seq_word(input logic [SEQ_W-1:0] s);
        return {{(WORD_W-SEQ_W){1'b0}}, s};
    endfunction

    function automatic logic [WORD_W-1:0] make_tag(input logic [VP_W-1:0] vp);
        return {TAG_MARK, 8'h00, vp, 8'h00};
    endfunction

    function automatic logic tag_marker_ok(input logic [WORD_W-1:0] w);
        return w[31:24] == TAG_MARK;
    endfunction

    function automatic logic [VP_W-1:0] tag_vp(input logic [WORD_W-1:0] w);
        return w[15:8];
    endfunction

endpackage

// File: rtl/vp_replay_table.sv
module vp_replay_table
    import vp_tag_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic [VP_W-1:0]  wr_vp,
    input  logic [SEQ_W-1:0] rd_seq,
    output logic [VP_W-1:0]  rd_vp
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [VP_W-1:0] vp_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) vp_mem[i] <= '0;
        end else if (wr_en) begin
            vp_mem[wr_seq[IDX_W-1:0]] <= wr_vp;
        end
    end

    assign rd_vp = vp_mem[rd_seq[IDX_W-1:0]];

endmodule

// File: rtl/vp_tag_tx.sv
module vp_tag_tx
    import vp_tag_pkg::*;
#(
    parameter int REPLAY_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mr_en,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [VP_W-1:0]   in_vp,
    input  logic              in_retry,
    output logic              in_ready,
    output lane_t             lnk
);
    tx_state_e         state;
    logic [WORD_W-1:0] crc_q;
    logic [VP_W-1:0]   vp_q;
    logic [VP_W-1:0]   replay_vp;
    logic              start;
    logic [WORD_W-1:0] seq_w;
    logic [WORD_W-1:0] tag_w;

    assign start    = (state == TXS_IDLE) && in_valid && in_sop;
    assign in_ready = (state == TXS_BODY);
    assign seq_w    = make_seq_word(in_seq);
    assign tag_w    = make_tag(vp_q);

    vp_replay_table #(.DEPTH(REPLAY_DEPTH)) u_replay (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (start && !in_retry),
        .wr_seq (in_seq),
        .wr_vp  (in_vp),
        .rd_seq (in_seq),
        .rd_vp  (replay_vp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TXS_IDLE;
            lnk   <= '0;
            crc_q <= CRC_SEED;
            vp_q  <= '0;
        end else begin
            lnk.valid <= 1'b0;
            lnk.sop   <= 1'b0;
            lnk.eop   <= 1'b0;
            unique case (state)
                TXS_IDLE: begin
                    if (start) begin
                        lnk   <= '{valid: 1'b1, sop: 1'b1, eop: 1'b0, data: seq_w};
                        crc_q <= crc_step(CRC_SEED, seq_w);
                        vp_q  <= in_retry ? replay_vp : in_vp;
                        state <= mr_en ? TXS_TAG : TXS_BODY;
                    end
                end
                TXS_TAG: begin
                    lnk   <= '{valid: 1'b1, sop: 1'b0, eop: 1'b0, data: tag_w};
                    crc_q <= crc_step(crc_q, tag_w);
                    state <= TXS_BODY;
                end
                TXS_BODY: begin
                    if (in_valid) begin
                        lnk   <= '{valid: 1'b1, sop: 1'b0, eop: 1'b0, data: in_data};
                        crc_q <= crc_step(crc_q, in_data);
                        if (in_eop) state <= TXS_CRC;
                    end
                end
                TXS_CRC: begin
                    lnk   <= '{valid: 1'b1, sop: 1'b0, eop: 1'b1, data: ~crc_q};
                    state <= TXS_IDLE;
                end
                default: state <= TXS_IDLE;
            endcase
        end
    end

    // R1: the sequence word is always followed at once by a non-final, non-start word
    a_r1_seq_then_body: assert property (@(posedge clk) disable iff (rst)
        (lnk.valid && lnk.sop) |=> (lnk.valid && !lnk.sop && !lnk.eop));

    // R1: the CRC word never doubles as the start word
    a_r1_eop_not_sop: assert property (@(posedge clk) disable iff (rst)
        (lnk.valid && lnk.eop) |-> !lnk.sop);

    // R1: after a frame ends, the link either idles or starts a new frame
    a_r1_eop_then_gap_or_new: assert property (@(posedge clk) disable iff (rst)
        (lnk.valid && lnk.eop) |=> (!lnk.valid || lnk.sop));

endmodule

// File: rtl/vp_tag_rx.sv
module vp_tag_rx
    import vp_tag_pkg::*;
#(
    parameter int MAX_TLP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mr_en,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output lane_t             up,
    output logic [SEQ_W-1:0]  up_seq,
    output logic [VP_W-1:0]   up_vp,
    output logic              err_crc,
    output logic              err_tag,
    output logic              err_len
);
    localparam int BUF_D = MAX_TLP_W + 2;
    localparam int SAT_N = BUF_D + 1;
    localparam int CNT_W = $clog2(MAX_TLP_W + 5);
    localparam int IDX_W = $clog2(BUF_D);
    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_D);
    localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'(SAT_N);
    localparam logic [CNT_W-1:0] MAX_TLP = CNT_W'(MAX_TLP_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  rd_q;
    logic [CNT_W-1:0]  last_q;
    logic              first_q;
    logic              mode_q;
    logic              tag_bad_q;
    logic [WORD_W-1:0] crc_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [VP_W-1:0]   vp_q;
    logic [WORD_W-1:0] frame_mem [BUF_D];

    logic [CNT_W-1:0]  idx;
    logic              mode_now;
    logic [CNT_W-1:0]  hdr_now;
    logic [WORD_W-1:0] crc_base;
    logic              take;
    logic              crc_ok;
    logic              len_ok;
    logic              tag_bad_now;

    always_comb begin
        idx         = in_sop ? '0 : cnt;
        mode_now    = in_sop ? mr_en : mode_q;
        hdr_now     = mode_now ? CNT_W'(2) : CNT_W'(1);
        crc_base    = (idx == '0) ? CRC_SEED : crc_q;
        take        = (state == RXS_COLLECT) && in_valid;
        crc_ok      = (in_data == ~crc_base);
        len_ok      = (idx >= hdr_now + CNT_W'(1)) && (idx <= hdr_now + MAX_TLP);
        tag_bad_now = mode_now && (idx >= CNT_W'(2)) && tag_bad_q;
    end

    assign in_ready = (state == RXS_COLLECT);
    assign up_seq   = seq_q;
    assign up_vp    = vp_q;

    always_ff @(posedge clk) begin
        if (take && !in_eop && (idx < BUF_LIM)) frame_mem[idx[IDX_W-1:0]] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RXS_COLLECT;
            cnt       <= '0;
            rd_q      <= '0;
            last_q    <= '0;
            first_q   <= 1'b0;
            mode_q    <= 1'b0;
            tag_bad_q <= 1'b0;
            crc_q     <= CRC_SEED;
            seq_q     <= '0;
            vp_q      <= '0;
            up        <= '0;
            err_crc   <= 1'b0;
            err_tag   <= 1'b0;
            err_len   <= 1'b0;
        end else begin
            up.valid <= 1'b0;
            up.sop   <= 1'b0;
            up.eop   <= 1'b0;
            err_crc  <= 1'b0;
            err_tag  <= 1'b0;
            err_len  <= 1'b0;
            unique case (state)
                RXS_COLLECT: begin
                    if (take && !in_eop) begin
                        crc_q <= crc_step(crc_base, in_data);
                        cnt   <= (idx < SAT_LIM) ? idx + CNT_W'(1) : SAT_LIM;
                        if (idx == '0) begin
                            seq_q     <= in_data[SEQ_W-1:0];
                            mode_q    <= mr_en;
                            vp_q      <= '0;
                            tag_bad_q <= 1'b0;
                        end
                        if ((idx == CNT_W'(1)) && mode_now) begin
                            vp_q      <= tag_vp(in_data);
                            tag_bad_q <= !tag_marker_ok(in_data);
                        end
                    end else if (take && in_eop) begin
                        cnt     <= '0;
                        err_crc <= !crc_ok;
                        err_len <= !len_ok;
                        err_tag <= tag_bad_now;
                        if (idx == '0) begin
                            mode_q <= mr_en;
                            vp_q   <= '0;
                        end
                        if (crc_ok && len_ok && !tag_bad_now) begin
                            state   <= RXS_PLAY;
                            rd_q    <= hdr_now;
                            last_q  <= idx - CNT_W'(1);
                            first_q <= 1'b1;
                        end
                    end
                end
                RXS_PLAY: begin
                    up.valid <= 1'b1;
                    up.sop   <= first_q;
                    up.eop   <= (rd_q == last_q);
                    up.data  <= frame_mem[rd_q[IDX_W-1:0]];
                    first_q  <= 1'b0;
                    rd_q     <= rd_q + CNT_W'(1);
                    if (rd_q == last_q) state <= RXS_COLLECT;
                end
                default: state <= RXS_COLLECT;
            endcase
        end
    end

    // R6/R7/R8: a dropped frame never shows up as upstream data in the same cycle
    a_r6_drop_no_output: assert property (@(posedge clk) disable iff (rst)
        (err_crc || err_tag || err_len) |-> !up.valid);

    // R6: an error report lasts a single cycle
    a_r6_crc_pulse: assert property (@(posedge clk) disable iff (rst)
        err_crc |=> !err_crc);

    // R5: the last upstream word closes the packet
    a_r5_eop_closes: assert property (@(posedge clk) disable iff (rst)
        (up.valid && up.eop) |=> !up.valid);

    // R5: no link word is taken while a packet is still being delivered
    a_r5_hold_while_play: assert property (@(posedge clk) disable iff (rst)
        (up.valid && !up.eop) |-> !in_ready);

    // R3: base framing reports plane zero
    a_r3_base_vp_zero: assert property (@(posedge clk) disable iff (rst)
        (up.valid && !mode_q) |-> (up_vp == '0));

endmodule

// File: rtl/vp_tag_codec.sv
module vp_tag_codec
    import vp_tag_pkg::*;
#(
    parameter int MAX_TLP_W    = 16,
    parameter int REPLAY_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mr_en,
    input  logic        tl_tx_valid,
    input  logic        tl_tx_sop,
    input  logic        tl_tx_eop,
    input  logic [31:0] tl_tx_data,
    input  logic [11:0] tl_tx_seq,
    input  logic [7:0]  tl_tx_vp,
    input  logic        tl_tx_retry,
    output logic        tl_tx_ready,
    output logic        lnk_tx_valid,
    output logic        lnk_tx_sop,
    output logic        lnk_tx_eop,
    output logic [31:0] lnk_tx_data,
    input  logic        lnk_rx_valid,
    input  logic        lnk_rx_sop,
    input  logic        lnk_rx_eop,
    input  logic [31:0] lnk_rx_data,
    output logic        lnk_rx_ready,
    output logic        tl_rx_valid,
    output logic        tl_rx_sop,
    output logic        tl_rx_eop,
    output logic [31:0] tl_rx_data,
    output logic [11:0] tl_rx_seq,
    output logic [7:0]  tl_rx_vp,
    output logic        err_crc,
    output logic        err_tag,
    output logic        err_len
);
    lane_t tx_lane;
    lane_t rx_lane;

    vp_tag_tx #(.REPLAY_DEPTH(REPLAY_DEPTH)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .mr_en    (mr_en),
        .in_valid (tl_tx_valid),
        .in_sop   (tl_tx_sop),
        .in_eop   (tl_tx_eop),
        .in_data  (tl_tx_data),
        .in_seq   (tl_tx_seq),
        .in_vp    (tl_tx_vp),
        .in_retry (tl_tx_retry),
        .in_ready (tl_tx_ready),
        .lnk      (tx_lane)
    );

    vp_tag_rx #(.MAX_TLP_W(MAX_TLP_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mr_en    (mr_en),
        .in_valid (lnk_rx_valid),
        .in_sop   (lnk_rx_sop),
        .in_eop   (lnk_rx_eop),
        .in_data  (lnk_rx_data),
        .in_ready (lnk_rx_ready),
        .up       (rx_lane),
        .up_seq   (tl_rx_seq),
        .up_vp    (tl_rx_vp),
        .err_crc  (err_crc),
        .err_tag  (err_tag),
        .err_len  (err_len)
    );

    assign lnk_tx_valid = tx_lane.valid;
    assign lnk_tx_sop   = tx_lane.sop;
    assign lnk_tx_eop   = tx_lane.eop;
    assign lnk_tx_data  = tx_lane.data;

    assign tl_rx_valid  = rx_lane.valid;
    assign tl_rx_sop    = rx_lane.sop;
    assign tl_rx_eop    = rx_lane.eop;
    assign tl_rx_data   = rx_lane.data;

endmodule

// File: tb/vp_tag_codec_tb.sv
`timescale 1ns/1ps
module vp_tag_codec_tb;
    localparam int MAXW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mr_en = 1'b1;
    logic        tl_tx_valid = 1'b0, tl_tx_sop = 1'b0, tl_tx_eop = 1'b0, tl_tx_retry = 1'b0;
    logic [31:0] tl_tx_data = '0;
    logic [11:0] tl_tx_seq = '0;
    logic [7:0]  tl_tx_vp = '0;
    logic        tl_tx_ready;
    logic        lnk_tx_valid, lnk_tx_sop, lnk_tx_eop;
    logic [31:0] lnk_tx_data;
    logic        lnk_rx_valid = 1'b0, lnk_rx_sop = 1'b0, lnk_rx_eop = 1'b0;
    logic [31:0] lnk_rx_data = '0;
    logic        lnk_rx_ready;
    logic        tl_rx_valid, tl_rx_sop, tl_rx_eop;
    logic [31:0] tl_rx_data;
    logic [11:0] tl_rx_seq;
    logic [7:0]  tl_rx_vp;
    logic        err_crc, err_tag, err_len;

    vp_tag_codec #(.MAX_TLP_W(MAXW), .REPLAY_DEPTH(8)) u_dut (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] pay[$];
    logic [31:0] exp_q[$];
    logic [31:0] txc_d[$];
    bit          txc_s[$];
    bit          txc_e[$];
    logic [31:0] rxc_d[$];
    bit          rxc_s[$];
    bit          rxc_e[$];
    logic [7:0]  rxc_vp;
    logic [11:0] rxc_seq;
    int n_ecrc = 0, n_etag = 0, n_elen = 0;

    always @(negedge clk) begin
        if (lnk_tx_valid) begin
            txc_d.push_back(lnk_tx_data);
            txc_s.push_back(lnk_tx_sop);
            txc_e.push_back(lnk_tx_eop);
        end
        if (tl_rx_valid) begin
            rxc_d.push_back(tl_rx_data);
            rxc_s.push_back(tl_rx_sop);
            rxc_e.push_back(tl_rx_eop);
            rxc_vp  = tl_rx_vp;
            rxc_seq = tl_rx_seq;
        end
        if (err_crc) n_ecrc++;
        if (err_tag) n_etag++;
        if (err_len) n_elen++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int b = 31; b >= 0; b--) begin
            if (r[31] != d[b]) r = (r << 1) ^ 32'h04C11DB7;
            else               r = r << 1;
        end
        return r;
    endfunction

    task automatic build_frame(input logic [11:0] seq, input logic [7:0] vp, input bit mr,
                               input logic [7:0] marker);
        logic [31:0] c;
        exp_q.delete();
        exp_q.push_back({20'h0, seq});
        if (mr) exp_q.push_back({marker, 8'h00, vp, 8'h00});
        foreach (pay[i]) exp_q.push_back(pay[i]);
        c = 32'hFFFF_FFFF;
        foreach (exp_q[i]) c = ref_step(c, exp_q[i]);
        exp_q.push_back(~c);
    endtask

    task automatic make_pay(input int n, input logic [31:0] base);
        pay.delete();
        for (int i = 0; i < n; i++) pay.push_back(base + 32'h0101_0101 * i);
    endtask

    task automatic clear_caps();
        txc_d.delete(); txc_s.delete(); txc_e.delete();
        rxc_d.delete(); rxc_s.delete(); rxc_e.delete();
        n_ecrc = 0; n_etag = 0; n_elen = 0;
    endtask

    task automatic send_tx(input logic [11:0] seq, input logic [7:0] vp, input bit retry);
        @(negedge clk);
        for (int i = 0; i < pay.size(); i++) begin
            tl_tx_valid = 1'b1;
            tl_tx_sop   = (i == 0);
            tl_tx_eop   = (i == pay.size() - 1);
            tl_tx_data  = pay[i];
            tl_tx_seq   = seq;
            tl_tx_vp    = vp;
            tl_tx_retry = retry;
            while (!tl_tx_ready) @(negedge clk);
            @(negedge clk);
        end
        tl_tx_valid = 1'b0; tl_tx_sop = 1'b0; tl_tx_eop = 1'b0; tl_tx_retry = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_rx();
        @(negedge clk);
        for (int i = 0; i < exp_q.size(); i++) begin
            lnk_rx_valid = 1'b1;
            lnk_rx_sop   = (i == 0);
            lnk_rx_eop   = (i == exp_q.size() - 1);
            lnk_rx_data  = exp_q[i];
            while (!lnk_rx_ready) @(negedge clk);
            @(negedge clk);
        end
        lnk_rx_valid = 1'b0; lnk_rx_sop = 1'b0; lnk_rx_eop = 1'b0;
        repeat (MAXW + 8) @(negedge clk);
    endtask

    task automatic check_tx_frame(input string req);
        bit ok = (txc_d.size() == exp_q.size());
        chk(ok, {req, " frame length"}, txc_d.size(), exp_q.size());
        if (ok) begin
            for (int i = 0; i < exp_q.size(); i++) begin
                chk(txc_d[i] == exp_q[i], {req, " word"}, txc_d[i], exp_q[i]);
                chk(txc_s[i] == (i == 0), {req, " sop flag"}, txc_s[i], (i == 0));
                chk(txc_e[i] == (i == exp_q.size() - 1), {req, " eop flag"}, txc_e[i],
                    (i == exp_q.size() - 1));
            end
        end
    endtask

    task automatic check_rx_good(input string req, input logic [7:0] vp, input logic [11:0] seq);
        bit ok = (rxc_d.size() == pay.size());
        chk(ok, {req, " delivered length"}, rxc_d.size(), pay.size());
        if (ok) begin
            for (int i = 0; i < pay.size(); i++) begin
                chk(rxc_d[i] == pay[i], {req, " word"}, rxc_d[i], pay[i]);
                chk(rxc_s[i] == (i == 0), {req, " sop flag"}, rxc_s[i], (i == 0));
                chk(rxc_e[i] == (i == pay.size() - 1), {req, " eop flag"}, rxc_e[i],
                    (i == pay.size() - 1));
            end
            chk(rxc_vp == vp, {req, " vp"}, rxc_vp, vp);
            chk(rxc_seq == seq, {req, " seq"}, rxc_seq, seq);
        end
        chk((n_ecrc + n_etag + n_elen) == 0, {req, " no error"}, n_ecrc + n_etag + n_elen, 0);
    endtask

    task automatic check_dropped(input string req, input int got, input int expn);
        chk(got == expn, {req, " error pulses"}, got, expn);
        chk(rxc_d.size() == 0, {req, " nothing delivered"}, rxc_d.size(), 0);
    endtask

    task automatic t_reset_state();
        // R9
        chk(!lnk_tx_valid, "R9 lnk_tx_valid", lnk_tx_valid, 0);
        chk(!tl_tx_ready, "R9 tl_tx_ready", tl_tx_ready, 0);
        chk(lnk_rx_ready, "R9 lnk_rx_ready", lnk_rx_ready, 1);
        chk(!tl_rx_valid, "R9 tl_rx_valid", tl_rx_valid, 0);
        chk(!err_crc && !err_tag && !err_len, "R9 errors", {err_crc, err_tag, err_len}, 0);
    endtask

    task automatic t_tx_mr();
        // R1 R2: payload with marker-like top byte must pass unchanged
        clear_caps(); mr_en = 1'b1;
        make_pay(4, 32'hA500_1234);
        build_frame(12'h123, 8'h5C, 1'b1, 8'hA5);
        send_tx(12'h123, 8'h5C, 1'b0);
        check_tx_frame("R1 R2 tagged tx");
    endtask

    task automatic t_tx_base();
        // R3
        clear_caps(); mr_en = 1'b0;
        make_pay(3, 32'h0BAD_F00D);
        build_frame(12'h7FE, 8'h00, 1'b0, 8'hA5);
        send_tx(12'h7FE, 8'h3C, 1'b0);
        check_tx_frame("R3 base tx");
        mr_en = 1'b1;
    endtask

    task automatic t_tx_retry();
        // R4
        mr_en = 1'b1;
        make_pay(2, 32'h1111_0000);
        send_tx(12'h005, 8'h33, 1'b0);
        send_tx(12'h006, 8'h44, 1'b0);
        clear_caps();
        build_frame(12'h005, 8'h33, 1'b1, 8'hA5);
        send_tx(12'h005, 8'h99, 1'b1);
        check_tx_frame("R4 replay tag");
    endtask

    task automatic t_rx_good();
        // R5
        clear_caps(); mr_en = 1'b1;
        make_pay(5, 32'hCAFE_0001);
        build_frame(12'h0AB, 8'hE7, 1'b1, 8'hA5);
        send_rx();
        check_rx_good("R5 tagged rx", 8'hE7, 12'h0AB);
    endtask

    task automatic t_rx_base();
        // R3
        clear_caps(); mr_en = 1'b0;
        make_pay(2, 32'h5A5A_0000);
        build_frame(12'h321, 8'h00, 1'b0, 8'hA5);
        send_rx();
        check_rx_good("R3 base rx", 8'h00, 12'h321);
        mr_en = 1'b1;
    endtask

    task automatic t_rx_bad_crc();
        // R6
        clear_caps(); mr_en = 1'b1;
        make_pay(3, 32'h7777_0000);
        build_frame(12'h010, 8'h21, 1'b1, 8'hA5);
        exp_q[exp_q.size() - 1] ^= 32'h0000_0100;
        send_rx();
        check_dropped("R6 crc", n_ecrc, 1);
    endtask

    task automatic t_rx_bad_tag();
        // R7
        clear_caps(); mr_en = 1'b1;
        make_pay(3, 32'h6666_0000);
        build_frame(12'h011, 8'h22, 1'b1, 8'h5A);
        send_rx();
        check_dropped("R7 marker", n_etag, 1);
        chk(n_ecrc == 0, "R7 crc still valid", n_ecrc, 0);
    endtask

    task automatic t_rx_lengths();
        // R8: empty, one over the limit, then exactly the limit
        clear_caps(); mr_en = 1'b1;
        pay.delete();
        build_frame(12'h020, 8'h01, 1'b1, 8'hA5);
        send_rx();
        check_dropped("R8 empty", n_elen, 1);
        clear_caps();
        make_pay(MAXW + 1, 32'h2000_0000);
        build_frame(12'h021, 8'h02, 1'b1, 8'hA5);
        send_rx();
        check_dropped("R8 too long", n_elen, 1);
        clear_caps();
        make_pay(MAXW, 32'h3000_0000);
        build_frame(12'h022, 8'h03, 1'b1, 8'hA5);
        send_rx();
        check_rx_good("R8 max length", 8'h03, 12'h022);
    endtask

    task automatic t_loopback();
        // R1 R5: a transmitted frame is accepted by the receiver
        clear_caps(); mr_en = 1'b1;
        make_pay(6, 32'h4242_0000);
        send_tx(12'hFFF, 8'hFF, 1'b0);
        exp_q.delete();
        foreach (txc_d[i]) exp_q.push_back(txc_d[i]);
        send_rx();
        check_rx_good("R1 R5 loopback", 8'hFF, 12'hFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_tx_mr();
        t_tx_base();
        t_tx_retry();
        t_rx_good();
        t_rx_base();
        t_rx_bad_crc();
        t_rx_bad_tag();
        t_rx_lengths();
        t_loopback();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule